// File: doc/BRIEF.md
# Clock configuration register bank with atomic divider load

This block is the storage back end behind a two-wire serial slave in a display clock front end. A simple byte bus presents an address, a write strobe and a data byte. The block holds the settings that steer a downstream line-locked clock generator. These are a 12-bit line divide ratio, a VCO band selector, a charge-pump current code and a sampling-phase code. It also holds a fixed revision byte. Any address can be read back combinationally through `bus_rdata`.

The divide ratio is wider than one byte, so it spans two addresses. It is double-buffered. Writes land in staging registers. The active copy seen by the clock generator changes only when the low-nibble address is written. That write moves the whole 12-bit value at once and raises a one-cycle load pulse. A write to the high byte on its own therefore never exposes a half-updated ratio.

Decoded side outputs spare the downstream logic from re-deriving the settings:
- the line count, which is the active ratio plus one;
- a validity flag for the VCO band;
- the pump current in microamps;
- the sampling phase in quarter-degrees.

Top module: `cfg_regbank`

## Requirements
- R1: Address 0x00 always reads the revision parameter `REV_ID` (default 0x00), and a write to address 0x00 changes no stored value and no output.
- R2: After reset the divide value is 1693, so address 0x01 reads 0x69 and address 0x02 reads 0xD0. Address 0x03 reads 0x48 (band 01, pump code 001), and address 0x04 reads 0x80 (phase code 16).
- R3: A write to 0x01 stores the data byte as divider bits 11..4 in the staging register, which reads back at 0x01. It leaves `div_active` and `line_count` unchanged.
- R4: A write to 0x02 stores data bits 7..4 as divider bits 3..0. On the next clock edge it loads `div_active` with {staged bits 11..4, data bits 7..4}. `div_load_pulse` is high for exactly the cycle after each such write and low otherwise; back-to-back writes keep it high.
- R5: `line_count` equals `div_active` + 1 on 13 bits, so 0xFFF gives 4096.
- R6: At address 0x03, data bits 7..6 are the VCO band and bits 5..3 are the pump code; these appear on `vco_band` and read back in the same positions. Unused low bits of 0x02, 0x03 and 0x04 read as zero.
- R7: `vco_band_valid` is high for band codes 00, 01 and 10, and low for the reserved code 11. The reserved code is still stored and read back as written.
- R8: `pump_ua` gives the current for pump codes 0..7 as 50, 100, 150, 250, 350, 500, 750 and 1500 µA.
- R9: At address 0x04, data bits 7..3 are the sampling-phase code on `phase_code`. `phase_qdeg` equals code × 45, which is 11.25° per step in quarter-degrees.
- R10: Addresses above 0x04 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational readback of `bus_addr` |
| div_active | output | 12 | Active divide ratio |
| line_count | output | 13 | Active ratio plus one |
| div_load_pulse | output | 1 | High the cycle after the active ratio was loaded |
| vco_band | output | 2 | Stored VCO band code |
| vco_band_valid | output | 1 | Band code is not the reserved value |
| pump_ua | output | 11 | Charge-pump current in µA |
| phase_code | output | 5 | Sampling-phase step |
| phase_qdeg | output | 11 | Sampling phase in quarter-degrees |

## Verification
Two functions meet in adjacent cycles. The first is the atomic load into the active copy, with its pulse. The second is a fresh write to the staging high byte or to the low nibble.

The bench issues a 0x02 write directly followed by a 0x01 write, and back-to-back 0x02 writes. It judges several things against a behavioural model on every cycle: that the active value holds the high byte staged before the load, that the new high byte stays invisible until the next low write, and that the pulse stays high across consecutive loads.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned UA_W      = 11;
   localparam int unsigned QDEG_W    = 11;
   localparam int unsigned QDEG_TURN = 1440;

   localparam logic [7:0] ADR_REV    = 8'h00;
   localparam logic [7:0] ADR_DIV_HI = 8'h01;
   localparam logic [7:0] ADR_DIV_LO = 8'h02;
   localparam logic [7:0] ADR_CLK    = 8'h03;
   localparam logic [7:0] ADR_PHASE  = 8'h04;
   localparam logic [7:0] ADR_LAST   = 8'h04;

   typedef struct packed {
      logic [1:0] band;
      logic [2:0] pump;
   } clk_cfg_t;

   localparam clk_cfg_t CLK_CFG_RST = '{band: 2'b01, pump: 3'b001};
   localparam logic [1:0] BAND_RESERVED = 2'b11;

   function automatic logic [UA_W-1:0] pump_code_to_ua(input logic [2:0] code);
      logic [UA_W-1:0] ua;
      case (code)
         3'd0:    ua = 11'd50;
         3'd1:    ua = 11'd100;
         3'd2:    ua = 11'd150;
         3'd3:    ua = 11'd250;
         3'd4:    ua = 11'd350;
         3'd5:    ua = 11'd500;
         3'd6:    ua = 11'd750;
         default: ua = 11'd1500;
      endcase
      return ua;
   endfunction

endpackage

// File: rtl/cfg_div_buffer.sv
module cfg_div_buffer
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned    DIV_W   = 12,
   parameter logic [DIV_W-1:0] DIV_RST = 12'd1693
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hi_we,
   input  logic                    lo_we,
   input  logic [BYTE_W-1:0]       wdata,
   output logic [BYTE_W-1:0]       hi_q,
   output logic [DIV_W-BYTE_W-1:0] lo_q,
   output logic [DIV_W-1:0]        active,
   output logic                    load_pulse
);

   localparam int unsigned LO_W = DIV_W - BYTE_W;

   if (DIV_W <= BYTE_W || DIV_W >= 2*BYTE_W) begin : g_bad_div_w
      $error("cfg_div_buffer: DIV_W must lie strictly between one and two bytes");
   end

   logic [LO_W-1:0] lo_in;
   assign lo_in = wdata[BYTE_W-1 -: LO_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q       <= DIV_RST[DIV_W-1 -: BYTE_W];
         lo_q       <= DIV_RST[LO_W-1:0];
         active     <= DIV_RST;
         load_pulse <= 1'b0;
      end else begin
         load_pulse <= lo_we;
         if (hi_we) begin
            hi_q <= wdata;
         end
         if (lo_we) begin
            lo_q   <= lo_in;
            active <= {hi_q, lo_in};
         end
      end
   end

   // R3: a staging-only write must leave the active ratio alone
   a_r3_hi_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && !lo_we) |=> $stable(active));

   // R4: a low-nibble write is followed by the load pulse
   a_r4_pulse_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> load_pulse);

   // R4: the pulse is never raised without a low-nibble write before it
   a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> $past(lo_we));

   // R4: after a load the active ratio matches both staging parts
   a_r4_active_matches_stage: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> (active == {hi_q, lo_q}));

endmodule

// File: rtl/cfg_clk_fields.sv
module cfg_clk_fields
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned PHASE_W   = 5,
   parameter int unsigned PHASE_RST = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_we,
   input  logic               phase_we,
   input  logic [BYTE_W-1:0]  wdata,
   output clk_cfg_t           clk_cfg,
   output logic [PHASE_W-1:0] phase_q
);

   if (PHASE_W < 1 || PHASE_W > 5) begin : g_bad_phase_w
      $error("cfg_clk_fields: PHASE_W must be 1..5");
   end
   if (PHASE_RST >= (1 << PHASE_W)) begin : g_bad_phase_rst
      $error("cfg_clk_fields: PHASE_RST does not fit PHASE_W");
   end

   localparam logic [PHASE_W-1:0] PH_RST = PHASE_W'(PHASE_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_cfg <= CLK_CFG_RST;
         phase_q <= PH_RST;
      end else begin
         if (clk_we) begin
            clk_cfg.band <= wdata[7:6];
            clk_cfg.pump <= wdata[5:3];
         end
         if (phase_we) begin
            phase_q <= wdata[BYTE_W-1 -: PHASE_W];
         end
      end
   end

   // R6: band and pump change only through a write to their address
   a_r6_clk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_we |=> ($stable(clk_cfg.band) && $stable(clk_cfg.pump)));

   // R9: the phase code changes only through a write to its address
   a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_we |=> $stable(phase_q));

endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned PHASE_W = 5,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  clk_cfg_t           clk_cfg,
   input  logic [PHASE_W-1:0] phase_q,
   output logic               band_valid,
   output logic [UA_W-1:0]    pump_ua,
   output logic [QDEG_W-1:0]  phase_qdeg
);

   localparam int unsigned QSTEP = QDEG_TURN >> PHASE_W;

   logic              valid_c;
   logic [UA_W-1:0]   ua_c;
   logic [QDEG_W-1:0] qdeg_c;

   always_comb begin
      valid_c = (clk_cfg.band != BAND_RESERVED);
      ua_c    = pump_code_to_ua(clk_cfg.pump);
      qdeg_c  = QDEG_W'(phase_q) * QDEG_W'(QSTEP);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            band_valid <= 1'b1;
            pump_ua    <= pump_code_to_ua(CLK_CFG_RST.pump);
            phase_qdeg <= '0;
         end else begin
            band_valid <= valid_c;
            pump_ua    <= ua_c;
            phase_qdeg <= qdeg_c;
         end
      end
   end else begin : g_comb
      assign band_valid = valid_c;
      assign pump_ua    = ua_c;
      assign phase_qdeg = qdeg_c;
   end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfg_regbank_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 8,
   parameter int unsigned      DIV_W      = 12,
   parameter logic [DIV_W-1:0] DIV_RST    = 12'd1693,
   parameter int unsigned      PHASE_W    = 5,
   parameter int unsigned      PHASE_RST  = 16,
   parameter logic [7:0]       REV_ID     = 8'h00,
   parameter bit               DEC_REG    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic [DIV_W-1:0]   div_active,
   output logic [DIV_W:0]     line_count,
   output logic               div_load_pulse,
   output logic [1:0]         vco_band,
   output logic               vco_band_valid,
   output logic [UA_W-1:0]    pump_ua,
   output logic [PHASE_W-1:0] phase_code,
   output logic [QDEG_W-1:0]  phase_qdeg
);

   localparam int unsigned LO_W = DIV_W - BYTE_W;
   localparam int unsigned LO_PAD = BYTE_W - LO_W;
   localparam int unsigned PH_PAD = BYTE_W - PHASE_W;

   if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_addr_w
      $error("cfg_regbank: ADDR_W must be 3..8");
   end

   logic [7:0] adr;
   assign adr = 8'(bus_addr);

   logic hi_we, lo_we, clk_we, phase_we;
   assign hi_we    = bus_wr && (adr == ADR_DIV_HI);
   assign lo_we    = bus_wr && (adr == ADR_DIV_LO);
   assign clk_we   = bus_wr && (adr == ADR_CLK);
   assign phase_we = bus_wr && (adr == ADR_PHASE);

   logic [BYTE_W-1:0] hi_q;
   logic [LO_W-1:0]   lo_q;
   clk_cfg_t          clk_cfg;

   cfg_div_buffer #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .hi_we      (hi_we),
      .lo_we      (lo_we),
      .wdata      (bus_wdata),
      .hi_q       (hi_q),
      .lo_q       (lo_q),
      .active     (div_active),
      .load_pulse (div_load_pulse)
   );

   cfg_clk_fields #(.PHASE_W(PHASE_W), .PHASE_RST(PHASE_RST)) i_fields (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_we   (clk_we),
      .phase_we (phase_we),
      .wdata    (bus_wdata),
      .clk_cfg  (clk_cfg),
      .phase_q  (phase_code)
   );

   cfg_decode #(.PHASE_W(PHASE_W), .REG_OUT(DEC_REG)) i_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_cfg    (clk_cfg),
      .phase_q    (phase_code),
      .band_valid (vco_band_valid),
      .pump_ua    (pump_ua),
      .phase_qdeg (phase_qdeg)
   );

   assign vco_band   = clk_cfg.band;
   assign line_count = {1'b0, div_active} + 1'b1;

   always_comb begin
      case (adr)
         ADR_REV:    bus_rdata = REV_ID;
         ADR_DIV_HI: bus_rdata = hi_q;
         ADR_DIV_LO: bus_rdata = {lo_q, {LO_PAD{1'b0}}};
         ADR_CLK:    bus_rdata = {clk_cfg.band, clk_cfg.pump, 3'b000};
         ADR_PHASE:  bus_rdata = {phase_code, {PH_PAD{1'b0}}};
         default:    bus_rdata = 8'h00;
      endcase
   end

   // R1: the revision byte is constant at its address
   a_r1_rev_read: assert property (@(posedge clk) disable iff (!rst_n)
      (adr == ADR_REV) |-> (bus_rdata == REV_ID));

   // R10: unmapped addresses read as zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (adr > ADR_LAST) |-> (bus_rdata == 8'h00));

   // R5: the line count tracks the active ratio across a load
   a_r5_count_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(div_active) |-> $stable(line_count));

endmodule

// File: tb/test_cfg_regbank.sv
module test_cfg_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [11:0] div_active;
   logic [12:0] line_count;
   logic        div_load_pulse;
   logic [1:0]  vco_band;
   logic        vco_band_valid;
   logic [10:0] pump_ua;
   logic [4:0]  phase_code;
   logic [10:0] phase_qdeg;

   always #4 clk = ~clk;

   cfg_regbank i_cfg_regbank (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .div_active     (div_active),
      .line_count     (line_count),
      .div_load_pulse (div_load_pulse),
      .vco_band       (vco_band),
      .vco_band_valid (vco_band_valid),
      .pump_ua        (pump_ua),
      .phase_code     (phase_code),
      .phase_qdeg     (phase_qdeg)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference state
   int m_hi = 'h69, m_lo = 'hD, m_act = 1693, m_band = 1, m_pump = 1, m_phase = 16, m_pulse = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ua_of(input int c);
      case (c)
         0: return 50;   1: return 100;  2: return 150;  3: return 250;
         4: return 350;  5: return 500;  6: return 750;  default: return 1500;
      endcase
   endfunction

   function automatic int rd_of(input int a);
      case (a)
         0: return 0;
         1: return m_hi;
         2: return m_lo * 16;
         3: return m_band * 64 + m_pump * 8;
         4: return m_phase * 8;
         default: return 0;
      endcase
   endfunction

   function automatic string rd_req(input int a);
      case (a)
         0: return "R1";
         1, 2: return "R3";
         3: return "R6";
         4: return "R9";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hi = 'h69; m_lo = 'hD; m_act = 1693;
         m_band = 1; m_pump = 1; m_phase = 16; m_pulse = 0;
      end else begin
         m_pulse = 0;
         if (bus_wr) begin
            case (int'(bus_addr))
               1: m_hi = int'(bus_wdata);
               2: begin
                  m_lo = int'(bus_wdata) >> 4;
                  m_act = m_hi * 16 + m_lo;
                  m_pulse = 1;
               end
               3: begin
                  m_band = int'(bus_wdata) >> 6;
                  m_pump = (int'(bus_wdata) >> 3) & 7;
               end
               4: m_phase = int'(bus_wdata) >> 3;
               default: ;
            endcase
         end
      end
   end

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(rd_req(int'(bus_addr)), int'(bus_rdata), rd_of(int'(bus_addr)));
         chk("R4 active", int'(div_active), m_act);
         chk("R4 pulse", int'(div_load_pulse), m_pulse);
         chk("R5", int'(line_count), m_act + 1);
         chk("R6 band", int'(vco_band), m_band);
         chk("R7", int'(vco_band_valid), (m_band != 3) ? 1 : 0);
         chk("R8", int'(pump_ua), ua_of(m_pump));
         chk("R9 code", int'(phase_code), m_phase);
         chk("R9 qdeg", int'(phase_qdeg), m_phase * 45);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 8'(a); bus_wr = 1'b1; bus_wdata = 8'(d);
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      bus_addr = 8'(a); bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   initial begin : watchdog
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #2;
      // R2: reset values at the outputs while reset is held
      chk("R2 active", int'(div_active), 1693);
      chk("R2 band", int'(vco_band), 1);
      chk("R2 pump", int'(pump_ua), 100);
      chk("R2 phase", int'(phase_code), 16);
      @(negedge clk);
      rst_n = 1'b1;
      // R2: reset readback
      rd(1); #2 chk("R2 rd01", int'(bus_rdata), 'h69);
      rd(2); #2 chk("R2 rd02", int'(bus_rdata), 'hD0);
      rd(3); #2 chk("R2 rd03", int'(bus_rdata), 'h48);
      rd(4); #2 chk("R2 rd04", int'(bus_rdata), 'h80);
      for (int a = 0; a < 8; a++) rd(a);
      rd(255);
      // R1: revision write ignored
      wr(0, 'hAA); rd(0); rd(1);
      // R3: high byte alone does not move the active ratio
      wr(1, 'h12); rd(1); rd(1); rd(2);
      #2 chk("R3 hold", int'(div_active), 1693);
      // R4: low write loads
      wr(2, 'h3F); rd(2); rd(1);
      // R4: load then immediate staging write
      wr(1, 'hFF); wr(2, 'hF5); wr(1, 'h00); rd(1); rd(2);
      #2 chk("R5 max", int'(line_count), 4096);
      // R4: back-to-back loads keep the pulse high
      wr(2, 'h00); wr(2, 'h20); rd(2);
      #2 chk("R5 min", int'(line_count), 3);
      // R6/R7/R8: every band and pump code, with junk low bits
      for (int i = 0; i < 32; i++) begin
         wr(3, (i << 3) | 7);
         rd(3);
      end
      // R9: every phase code
      for (int i = 0; i < 32; i++) begin
         wr(4, (i << 3) | 5);
         rd(4);
      end
      // R10: unmapped writes ignored
      wr(5, 'hFF); wr(255, 'h12); wr(7, 'h33);
      for (int a = 0; a < 8; a++) rd(a);
      rd(255);
      rd(0);
      @(negedge clk);
      #3;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule